// File: doc/BRIEF.md
# Polled Entropy Data Register

This block holds one 32-bit random word for software to read. It fetches each word from an external entropy source over a request/acknowledge handshake. Two read-only registers are exposed. One holds the data word. The other holds a status word whose bit 0 says whether the data is valid.

Software polls the status register until valid is set, then reads the data register. That read returns the word, discards it, and starts a fetch for the next word straight away. The block never sits idle. At every cycle it either holds a valid word or has a request outstanding. A request is already raised when reset releases.

Register reads are single-cycle strobes. Read data is registered and appears on `rdata_o` in the cycle after the strobe. Any state change caused by the read takes effect at that same clock edge.

Top module: `ent_poll_reg`

## Requirements
- R1: After reset release, valid is 0 and `ent_req_o` is 1 without any stimulus. A status read (offset 0x4) returns 0x0.
- R2: Once `ent_req_o` is high, it stays high in every cycle until `ent_ack_i` is sampled high. An `ent_ack_i` while `ent_req_o` is low has no effect: the stored word, valid and `ent_req_o` are unchanged.
- R3: At a clock edge where `ent_req_o` and `ent_ack_i` are both high, `ent_data_i` is captured, valid becomes 1 and `ent_req_o` becomes 0.
- R4: A read of the data register (offset 0x0) while valid returns the stored word on `rdata_o` after that edge. At the same edge valid becomes 0 and `ent_req_o` becomes 1.
- R5: A read of the data register while invalid returns 0x0 and has no side effect. The request stays up, and a later acknowledge still delivers its word.
- R6: A status read returns bit 0 equal to valid as it was before the read edge, with bits 31:1 equal to 0. A status read never changes state.
- R7: In every cycle after reset, valid is 1 or `ent_req_o` is 1.
- R8: A read at any offset other than 0x0 or 0x4 returns 0x0 and changes no state.
- R9: `ent_data_i` is sampled only at the acknowledge edge. Changes on it in other cycles do not alter the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | Register read strobe, one cycle per read |
| rd_addr_i | input | 3 | Byte offset of the read (0x0 data, 0x4 status) |
| rdata_o | output | 32 | Registered read data, valid the cycle after the strobe |
| ent_req_o | output | 1 | Request to the entropy source |
| ent_ack_i | input | 1 | Acknowledge from the entropy source, with data |
| ent_data_i | input | 32 | Random word from the entropy source |

## Verification
Every result is due one clock edge after its stimulus:
- After an acknowledge edge, valid and the dropped request are visible.
- After a read strobe edge, `rdata_o` shows the value and the consume side effects are visible.

The bench drives inputs on the falling edge and holds them for exactly one rising edge. It samples at the following falling edge, so each check falls in the first cycle where the result is due. Checks that a stimulus had no effect read the state back through the status and data registers before the next acknowledge.

// File: rtl/ent_poll_pkg.sv
package ent_poll_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_DATA = 3'h0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'h4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/ent_fetch_ctrl.sv
module ent_fetch_ctrl
  import ent_poll_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  consume_i,
  input  logic  ack_i,
  input  word_t ent_data_i,
  output logic  req_o,
  output logic  valid_o,
  output word_t word_o
);
  logic  req_q, valid_q;
  word_t word_q;
  logic  fill;

  assign fill = req_q & ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b1;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else if (fill) begin
      req_q   <= 1'b0;
      valid_q <= 1'b1;
      word_q  <= ent_data_i;
    end else if (consume_i) begin
      req_q   <= 1'b1;
      valid_q <= 1'b0;
      word_q  <= '0;
    end
  end

  assign req_o   = req_q;
  assign valid_o = valid_q;
  assign word_o  = word_q;

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !ack_i |=> req_q);
  a_r2_stray_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q && !consume_i |=> $stable(word_q) && valid_q);
  a_r3_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && ack_i |=> valid_q && !req_q && word_q == $past(ent_data_i));
  a_r4_consume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> !valid_q && req_q);
  a_r7_never_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q || req_q);
endmodule

// File: rtl/ent_reg_read.sv
module ent_reg_read
  import ent_poll_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              valid_i,
  input  word_t             word_i,
  output logic              consume_o,
  output word_t             rdata_o
);
  rd_sel_e sel;
  word_t   rdata_d, rdata_q;

  always_comb begin
    sel = SEL_NONE;
    if (rd_en_i) begin
      if (rd_addr_i == OFS_DATA)      sel = SEL_DATA;
      else if (rd_addr_i == OFS_STAT) sel = SEL_STAT;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_d = valid_i ? word_i : '0;
      SEL_STAT: rdata_d = {{(WORD_W-1){1'b0}}, valid_i};
      default:  rdata_d = '0;
    endcase
  end

  // only a read that finds a valid word consumes it
  assign consume_o = (sel == SEL_DATA) && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  a_r5_invalid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i == OFS_DATA && !valid_i |=> rdata_q == '0);
  a_r6_status_fmt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i == OFS_STAT |=>
      rdata_q[WORD_W-1:1] == '0 && rdata_q[0] == $past(valid_i));
  a_r8_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i != OFS_DATA && rd_addr_i != OFS_STAT |=> rdata_q == '0);
endmodule

// File: rtl/ent_poll_reg.sv
module ent_poll_reg
  import ent_poll_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              ent_req_o,
  input  logic              ent_ack_i,
  input  logic [WORD_W-1:0] ent_data_i
);
  logic  consume, valid;
  word_t word;

  ent_reg_read u_read (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .valid_i   (valid),
    .word_i    (word),
    .consume_o (consume),
    .rdata_o   (rdata_o)
  );

  ent_fetch_ctrl u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .consume_i  (consume),
    .ack_i      (ent_ack_i),
    .ent_data_i (ent_data_i),
    .req_o      (ent_req_o),
    .valid_o    (valid),
    .word_o     (word)
  );

  a_r1_req_out_of_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> ent_req_o);
endmodule

// File: tb/ent_poll_reg_tb_top.sv
`timescale 1ns/1ps
module ent_poll_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rdata;
  logic        req;
  logic        ack = 1'b0;
  logic [31:0] edata = '0;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ent_poll_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rdata_o(rdata), .ent_req_o(req), .ent_ack_i(ack), .ent_data_i(edata)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  // entropy stub: one acknowledge cycle carrying word w
  task automatic fill(input logic [31:0] w);
    @(negedge clk); ack = 1'b1; edata = w;
    @(negedge clk); ack = 1'b0; edata = ~w;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R1 req after reset", {31'b0, req}, 32'd1);
    chk("R7 req while invalid", {31'b0, req}, 32'd1);
    rd(3'h4, v); chk("R1 status after reset", v, 32'd0);
  endtask

  task automatic t_invalid_read;
    logic [31:0] v;
    rd(3'h0, v); chk("R5 invalid data reads zero", v, 32'd0);
    chk("R5 req kept", {31'b0, req}, 32'd1);
    repeat (4) @(negedge clk);
    chk("R2 req held without ack", {31'b0, req}, 32'd1);
  endtask

  task automatic t_fill_and_consume(input logic [31:0] w);
    logic [31:0] v;
    fill(w);
    chk("R3 req drops after ack", {31'b0, req}, 32'd0);
    rd(3'h4, v); chk("R6 status valid", v, 32'd1);
    rd(3'h4, v); chk("R6 status read no side effect", v, 32'd1);
    rd(3'h0, v); chk("R4 data word", v, w);
    chk("R4 req raised after consume", {31'b0, req}, 32'd1);
    rd(3'h4, v); chk("R4 valid cleared", v, 32'd0);
    rd(3'h0, v); chk("R5 reread after consume is zero", v, 32'd0);
  endtask

  task automatic t_stray_ack;
    logic [31:0] v;
    fill(32'hA5A5_0001);
    @(negedge clk); ack = 1'b1; edata = 32'hDEAD_BEEF;
    @(negedge clk); ack = 1'b0;
    chk("R2 stray ack req stays low", {31'b0, req}, 32'd0);
    rd(3'h0, v); chk("R2 stray ack word kept", v, 32'hA5A5_0001);
  endtask

  task automatic t_bus_noise;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); edata = 32'h1111_0000 + i;
    end
    fill(32'h0BAD_F00D);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); edata = 32'h2222_0000 + i;
    end
    rd(3'h0, v); chk("R9 only ack edge sampled", v, 32'h0BAD_F00D);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    fill(32'h1234_5678);
    for (int a = 1; a < 8; a++) begin
      if (a != 4) begin
        rd(a[2:0], v); chk("R8 unmapped reads zero", v, 32'd0);
      end
    end
    rd(3'h4, v); chk("R8 unmapped no side effect", v, 32'd1);
    rd(3'h0, v); chk("R8 word intact", v, 32'h1234_5678);
  endtask

  task automatic t_back_to_back;
    logic [31:0] v;
    fill(32'hCAFE_0001);
    @(negedge clk); rd_en = 1'b1; rd_addr = 3'h0;
    @(negedge clk); v = rdata;
    chk("R4 first of pair", v, 32'hCAFE_0001);
    @(negedge clk); rd_en = 1'b0; v = rdata;
    chk("R5 second of pair zero", v, 32'd0);
    chk("R7 req up after pair", {31'b0, req}, 32'd1);
    fill(32'hCAFE_0002);
    rd(3'h0, v); chk("R5 later ack still delivers", v, 32'hCAFE_0002);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_invalid_read();
    t_fill_and_consume(32'h8000_7FFF);
    t_fill_and_consume(32'hFFFF_FFFF);
    t_stray_ack();
    t_bus_noise();
    t_unmapped();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule